// File: doc/BRIEF.md
# Inverted Bit-Manipulation Unit

This block carries out single-bit operations on one data word. A bit index chooses one bit of the operand. Four operations fold the complement of that bit into the carry flag, which serves as a one-bit accumulator. Two operations write a complemented flag into the chosen bit: one uses carry and the other uses zero. One operation flips the chosen bit. The block takes an operation code, the index, the operand and the current condition-code byte. It returns the result word, a write-back strobe and the new condition-code byte.

The surrounding pipeline has already fetched the operand, from a register or from memory. That pipeline also writes the result back when the strobe is high. Both operand sources are treated the same way. Input and output each use a valid/ready handshake, and a single register stage lies between them.

Top module: `bitinv_unit`

## Requirements
- R1: The index `idx_i` picks bit `idx_i` (0 = LSB) of `data_i`. Operation codes: 0 inverted-AND, 1 inverted-OR, 2 inverted-XOR, 3 inverted-load, 4 inverted-carry-store, 5 inverted-zero-store, 6 toggle, 7 reserved. Condition-code bit positions: carry 0, overflow 1, zero 2, negative 3.
- R2: Inverted-AND sets carry to carry AND NOT bit. For example, with operand 0xA5 and carry set, index 6 keeps carry set and index 7 clears it.
- R3: Inverted-OR sets carry to carry OR NOT bit. For example, with operand 0xA5 and carry clear, index 6 sets carry and index 7 leaves it clear.
- R4: Inverted-XOR sets carry to carry XOR NOT bit. For example, with operand 0xA5 and carry set, index 6 clears carry and index 7 keeps it set.
- R5: Inverted-load sets carry to NOT bit, whatever the old carry was.
- R6: Inverted-carry-store writes NOT carry into the chosen bit and leaves every other bit and every flag unchanged. For example, with carry clear, index 6 turns 0xA5 into 0xE5.
- R7: Inverted-zero-store writes NOT zero-flag into the chosen bit and leaves the flags unchanged. For example, with Z set, index 7 turns 0xE5 into 0x65.
- R8: Toggle flips the chosen bit and leaves all flags unchanged. Toggling bits 7, 6, 5 and 4 in turn takes 0xA5 to 0x55.
- R9: No operation changes the overflow, negative or zero flags. The operations from R2 to R5 change carry only.
- R10: The operations from R2 to R5 keep write-back low and return the operand unchanged. Write-back goes high only for the operations in R6, R7 and R8.
- R11: The reserved code passes the operand and the condition-code byte through unchanged, with write-back low.
- R12: An input accepted on a clock edge appears at the outputs after that edge. While `out_ready_i` is low, the outputs stay valid and do not change, and `in_ready_o` is low. Reset clears `out_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation presented |
| in_ready_o | output | 1 | Operation can be accepted |
| op_i | input | 3 | Operation code (R1) |
| idx_i | input | IDX_W (3) | Bit index |
| data_i | input | DATA_W (8) | Operand |
| ccr_i | input | 8 | Current condition-code byte |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| res_o | output | DATA_W (8) | Result word |
| wb_o | output | 1 | Write result back |
| ccr_o | output | 8 | Updated condition-code byte |

## Verification
The bench uses the default DATA_W of 8, so the index is three bits wide. With that setting the sweep covers every index for every operation code, the reserved one included. Each case runs with carry and zero both clear and both set, over several operand patterns. The worked examples with 0xA5 and 0xE5 are reproduced exactly. One stall test holds the consumer off for several cycles to show that the result is held.

// File: rtl/bitinv_pkg.sv
package bitinv_pkg;
  typedef enum logic [2:0] {
    OP_ANDN = 3'd0,
    OP_ORN  = 3'd1,
    OP_XORN = 3'd2,
    OP_LDN  = 3'd3,
    OP_STCN = 3'd4,
    OP_STZN = 3'd5,
    OP_FLIP = 3'd6,
    OP_RSVD = 3'd7
  } bitinv_op_e;

  localparam int CCR_W = 8;
  localparam int C_POS = 0;
  localparam int V_POS = 1;
  localparam int Z_POS = 2;
  localparam int N_POS = 3;
endpackage

// File: rtl/bitinv_pick.sv
module bitinv_pick #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] mask_o,
  output logic              bit_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask_o[g] = (idx_i == IDX_W'(g));
  end

  assign bit_o = |(data_i & mask_o);

  always_comb begin
    assert ($onehot0(mask_o)) else $error("mask not one-hot");
  end
endmodule

// File: rtl/bitinv_alu.sv
module bitinv_alu
  import bitinv_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [2:0]        op_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CCR_W-1:0]  ccr_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wb_o,
  output logic [CCR_W-1:0]  ccr_o
);
  logic [DATA_W-1:0] mask;
  logic              sel_bit;
  logic              nb, cf, zf;
  bitinv_op_e        op;

  bitinv_pick #(.DATA_W(DATA_W)) u_pick (
    .data_i (data_i),
    .idx_i  (idx_i),
    .mask_o (mask),
    .bit_o  (sel_bit)
  );

  assign op = bitinv_op_e'(op_i);
  assign nb = ~sel_bit;
  assign cf = ccr_i[C_POS];
  assign zf = ccr_i[Z_POS];

  always_comb begin
    res_o = data_i;
    wb_o  = 1'b0;
    ccr_o = ccr_i;
    case (op)
      OP_ANDN: ccr_o[C_POS] = cf & nb;
      OP_ORN:  ccr_o[C_POS] = cf | nb;
      OP_XORN: ccr_o[C_POS] = cf ^ nb;
      OP_LDN:  ccr_o[C_POS] = nb;
      OP_STCN: begin
        res_o = (data_i & ~mask) | (mask & {DATA_W{~cf}});
        wb_o  = 1'b1;
      end
      OP_STZN: begin
        res_o = (data_i & ~mask) | (mask & {DATA_W{~zf}});
        wb_o  = 1'b1;
      end
      OP_FLIP: begin
        res_o = data_i ^ mask;
        wb_o  = 1'b1;
      end
      default: ;
    endcase
  end

  // R9: overflow, negative, zero never altered
  always_comb begin
    a_r9_vnz_kept: assert ((ccr_o[V_POS] == ccr_i[V_POS]) &&
                           (ccr_o[N_POS] == ccr_i[N_POS]) &&
                           (ccr_o[Z_POS] == ccr_i[Z_POS]))
      else $error("flag other than carry changed");
  end
endmodule

// File: rtl/bitinv_stage.sv
module bitinv_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] d_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] q_o
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready_o  = ~vld_q | out_ready_i;
  assign out_valid_o = vld_q;
  assign q_o         = dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_valid_i && in_ready_o) begin
      vld_q <= 1'b1;
      dat_q <= d_i;
    end else if (out_ready_i) begin
      vld_q <= 1'b0;
    end
  end

  // R12: stalled result held
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(q_o)))
    else $error("stalled output changed");

  // R12: accepted input visible next cycle
  a_r12_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (out_valid_o && q_o == $past(d_i)))
    else $error("accepted input not presented");
endmodule

// File: rtl/bitinv_unit.sv
module bitinv_unit
  import bitinv_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int PAY_W = DATA_W + 1 + CCR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [2:0]        op_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CCR_W-1:0]  ccr_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wb_o,
  output logic [CCR_W-1:0]  ccr_o
);
  logic [DATA_W-1:0] alu_res;
  logic              alu_wb;
  logic [CCR_W-1:0]  alu_ccr;
  logic [PAY_W-1:0]  pay_q;

  bitinv_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i   (op_i),
    .idx_i  (idx_i),
    .data_i (data_i),
    .ccr_i  (ccr_i),
    .res_o  (alu_res),
    .wb_o   (alu_wb),
    .ccr_o  (alu_ccr)
  );

  bitinv_stage #(.W(PAY_W)) u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .d_i         ({alu_res, alu_wb, alu_ccr}),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .q_o         (pay_q)
  );

  assign {res_o, wb_o, ccr_o} = pay_q;

  logic acc;
  assign acc = in_valid_i && in_ready_o;

  // R10: no write-back means operand returned unchanged
  a_r10_nowb_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (wb_o || res_o == $past(data_i)))
    else $error("result differs without write-back");

  // R6 R7 R8: stores and toggle keep all flags
  a_r6_store_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op_i inside {3'd4, 3'd5, 3'd6}) |=> (wb_o && ccr_o == $past(ccr_i)))
    else $error("store/toggle changed flags");

  // R8: toggle alters exactly one bit
  a_r8_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op_i == 3'd6) |=> ($countones(res_o ^ $past(data_i)) == 1))
    else $error("toggle did not flip one bit");

  // R6: store touches only the selected bit
  a_r6_only_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op_i inside {3'd4, 3'd5}) |=>
      ($countones(res_o ^ $past(data_i)) <= 1))
    else $error("store touched other bits");

  // R11: reserved code passes everything
  a_r11_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op_i == 3'd7) |=> (!wb_o && ccr_o == $past(ccr_i)))
    else $error("reserved code not transparent");
endmodule

// File: tb/bitinv_unit_test.sv
module bitinv_unit_test;
  localparam int PERIOD = 10;
  localparam int DATA_W = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic       in_ready_o;
  logic [2:0] op_i = '0;
  logic [2:0] idx_i = '0;
  logic [7:0] data_i = '0;
  logic [7:0] ccr_i = '0;
  logic       out_valid_o;
  logic       out_ready_i = 1'b1;
  logic [7:0] res_o;
  logic       wb_o;
  logic [7:0] ccr_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  bitinv_unit #(.DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .op_i(op_i), .idx_i(idx_i), .data_i(data_i), .ccr_i(ccr_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .res_o(res_o), .wb_o(wb_o), .ccr_o(ccr_o)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // independent reference of the requirements
  task automatic model(input logic [2:0] op, input logic [2:0] idx, input logic [7:0] d,
                       input logic [7:0] cc, output logic [7:0] r, output logic w,
                       output logic [7:0] co);
    logic b, c, z;
    b = d[idx]; c = cc[0]; z = cc[2];
    r = d; w = 1'b0; co = cc;
    if (op == 3'd0) co[0] = c && !b;
    else if (op == 3'd1) co[0] = c || !b;
    else if (op == 3'd2) co[0] = (c != !b);
    else if (op == 3'd3) co[0] = !b;
    else if (op == 3'd4) begin r[idx] = !c; w = 1'b1; end
    else if (op == 3'd5) begin r[idx] = !z; w = 1'b1; end
    else if (op == 3'd6) begin r[idx] = !d[idx]; w = 1'b1; end
  endtask

  // one transaction: drive on falling edge, read one cycle later
  task automatic issue(input logic [2:0] op, input logic [2:0] idx,
                       input logic [7:0] d, input logic [7:0] cc);
    @(negedge clk);
    op_i = op; idx_i = idx; data_i = d; ccr_i = cc; in_valid_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic run_one(string req, logic [2:0] op, logic [2:0] idx,
                         logic [7:0] d, logic [7:0] cc);
    logic [7:0] er, ec;
    logic ew;
    model(op, idx, d, cc, er, ew, ec);
    issue(op, idx, d, cc);
    chk({req, " valid"}, 16'(out_valid_o), 16'd1);
    chk({req, " res"}, 16'(res_o), 16'(er));
    chk({req, " wb"}, 16'(wb_o), 16'(ew));
    chk({req, " ccr"}, 16'(ccr_o), 16'(ec));
  endtask

  task automatic t_reset;
    chk("R12 reset valid", 16'(out_valid_o), 16'd0);
    chk("R12 reset ready", 16'(in_ready_o), 16'd1);
  endtask

  task automatic t_andn;  // R2
    issue(3'd0, 3'd6, 8'hA5, 8'h01); chk("R2 idx6 keep", 16'(ccr_o), 16'h01);
    issue(3'd0, 3'd7, 8'hA5, 8'h01); chk("R2 idx7 clr", 16'(ccr_o), 16'h00);
    issue(3'd0, 3'd6, 8'hA5, 8'h00); chk("R2 no set", 16'(ccr_o), 16'h00);
  endtask

  task automatic t_orn;  // R3
    issue(3'd1, 3'd6, 8'hA5, 8'h00); chk("R3 idx6 set", 16'(ccr_o), 16'h01);
    issue(3'd1, 3'd7, 8'hA5, 8'h00); chk("R3 idx7 clear", 16'(ccr_o), 16'h00);
    issue(3'd1, 3'd7, 8'hA5, 8'h01); chk("R3 keep set", 16'(ccr_o), 16'h01);
  endtask

  task automatic t_xorn;  // R4
    issue(3'd2, 3'd6, 8'hA5, 8'h01); chk("R4 idx6 clr", 16'(ccr_o), 16'h00);
    issue(3'd2, 3'd7, 8'hA5, 8'h01); chk("R4 idx7 keep", 16'(ccr_o), 16'h01);
    issue(3'd2, 3'd6, 8'hA5, 8'h00); chk("R4 idx6 set", 16'(ccr_o), 16'h01);
  endtask

  task automatic t_ldn;  // R5
    issue(3'd3, 3'd6, 8'hA5, 8'h00); chk("R5 idx6", 16'(ccr_o), 16'h01);
    issue(3'd3, 3'd7, 8'hA5, 8'h01); chk("R5 idx7", 16'(ccr_o), 16'h00);
    chk("R10 ldn no wb", 16'(wb_o), 16'd0);
    chk("R10 ldn res", 16'(res_o), 16'hA5);
  endtask

  task automatic t_stores;  // R6 R7
    issue(3'd4, 3'd6, 8'hA5, 8'h00); chk("R6 idx6", 16'(res_o), 16'hE5);
    chk("R6 wb", 16'(wb_o), 16'd1);
    issue(3'd4, 3'd7, 8'hE5, 8'h01); chk("R6 idx7", 16'(res_o), 16'h65);
    chk("R6 flags", 16'(ccr_o), 16'h01);
    issue(3'd5, 3'd6, 8'hA5, 8'h00); chk("R7 idx6", 16'(res_o), 16'hE5);
    issue(3'd5, 3'd7, 8'hE5, 8'h04); chk("R7 idx7", 16'(res_o), 16'h65);
    chk("R7 flags", 16'(ccr_o), 16'h04);
  endtask

  task automatic t_toggle;  // R8
    logic [7:0] v = 8'hA5;
    for (int i = 7; i >= 4; i--) begin
      issue(3'd6, 3'(i), v, 8'h00);
      v = res_o;
    end
    chk("R8 chain", 16'(v), 16'h55);
    chk("R8 flags", 16'(ccr_o), 16'h00);
  endtask

  task automatic t_sweep;  // R1 R9 R10 R11 all codes, all indices
    logic [7:0] pats [4] = '{8'hA5, 8'h5A, 8'h00, 8'hFF};
    logic [7:0] ccs [3] = '{8'h00, 8'h0F, 8'hF5};
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 8; i++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 3; c++)
            run_one(o == 7 ? "R11 sweep" : "R1 R9 R10 sweep", 3'(o), 3'(i), pats[p], ccs[c]);
  endtask

  task automatic t_stall;  // R12
    logic [7:0] held;
    @(negedge clk);
    out_ready_i = 1'b0;
    op_i = 3'd6; idx_i = 3'd0; data_i = 8'h10; ccr_i = 8'h00; in_valid_i = 1'b1;
    @(negedge clk);
    held = res_o;
    chk("R12 stall res", 16'(held), 16'h11);
    data_i = 8'h80;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R12 stall valid", 16'(out_valid_o), 16'd1);
      chk("R12 stall hold", 16'(res_o), 16'(held));
      chk("R12 stall ready", 16'(in_ready_o), 16'd0);
    end
    in_valid_i = 1'b0;
    out_ready_i = 1'b1;
    @(negedge clk);
    chk("R12 drained", 16'(out_valid_o), 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_andn();
    t_orn();
    t_xorn();
    t_ldn();
    t_stores();
    t_toggle();
    t_sweep();
    t_stall();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule